// File: doc/BRIEF.md
# I2S to Simultaneous-Mode Serial Converter

This block takes a standard I2S stereo stream (bit clock, word select, serial data) and re-times it for a multibit DAC that wants both channels at once. A fast system clock oversamples the three I2S lines. The left and right words are deserialized, and the left word waits in a holding register. Once the right word of the same frame has arrived, both words are loaded into two output shift registers. From there they are shifted out together, one on a left data line and one on a right data line, under a shared output clock.

The output clock runs only while the 16 data bits are on the lines. It can be inverted for converters that capture on the falling edge. After the last bit, a latch-enable pulse tells the DAC to load the pair. A second configuration input sends out the bitwise complement of both words, for converters that expect inverted codes.

The block is placed between an I2S source and the DAC's serial inputs. The system clock must run at least four times faster than the bit clock.

Top module: `i2s_to_simul`

## Requirements
- R1: In the input stream, word select low marks the left channel and high marks the right channel. Bits are sampled on rising bit-clock edges. The MSB of a word is the bit sampled on the second rising edge after word select changes. Only the first 16 bits of a slot are kept, and any further bits in a longer slot are ignored.
- R2: The left word appears on `dac_dl` and the right word on `dac_dr`, and the same output clock edges shift both lines.
- R3: Each word leaves MSB first and ends with the LSB. The MSB is already on the lines before the first active output clock edge, so there is no lead-in clock.
- R4: Every output word pair gets exactly 16 active output clock edges, and all 16 bits arrive intact, the LSB included.
- R5: Outside the 16-bit window, the output clock sits at its idle level and makes no edges. This applies during the latch pulse and while the block is idle.
- R6: With `cfg_clk_inv` low, the idle level is 0 and data is captured on the rising edge. With `cfg_clk_inv` high, the idle level is 1 and data is captured on the falling edge. In both cases the active edge falls in the middle of each bit.
- R7: `dac_le` goes high right after the LSB period. It stays high for one output clock period (2·HALF system clocks) and is low while bits are shifting.
- R8: With `cfg_data_inv` high, both output words are the full bitwise complement of the received words. For example, 0xFFFF goes out as 0x0000 and 0x8000 as 0x7FFF.
- R9: A pair goes out only after the right word that follows a complete left word has ended, which is marked by the next word-select change. A right word that was already running when the block left reset produces no output. Exactly one latch pulse occurs per stereo frame.
- R10: During and after reset, `dac_le`, `dac_dl` and `dac_dr` are 0, and `dac_clk` sits at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i2s_bck | input | 1 | I2S bit clock (asynchronous) |
| i2s_ws | input | 1 | I2S word select, low = left |
| i2s_sd | input | 1 | I2S serial data |
| cfg_clk_inv | input | 1 | Inverts the output clock polarity |
| cfg_data_inv | input | 1 | Outputs complemented data words |
| dac_clk | output | 1 | Gated output bit clock |
| dac_dl | output | 1 | Left channel serial data, MSB first |
| dac_dr | output | 1 | Right channel serial data, MSB first |
| dac_le | output | 1 | Latch-enable pulse, one per word pair |

## Verification
The hardest situations to reach are the word boundaries. One is the one-bit I2S lag, where the LSB of one channel shares a slot with the new word-select value. Another is the partial right word at the start of a stream, which must not produce a pair. The bench drives a continuous bit stream that delays data by one slot relative to word select. Each run starts with idle right-channel slots, and the run ends with a flush half-frame so that the last right word is closed by a real transition. Walking single-bit words show any dropped, swapped or misordered bit. Runs with 24-bit slots, whose padding bits are nonzero, confirm that only the leading 16 bits are kept. All four combinations of clock and data inversion are swept.

// File: rtl/i2s_simul_pkg.sv
package i2s_simul_pkg;
  parameter int DEF_WORD_W = 16;
  parameter int DEF_HALF   = 2;
  parameter int DEF_SYNC   = 2;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_LATCH = 2'd2
  } tx_state_t;
endpackage

// File: rtl/i2s_in_sync.sv
module i2s_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck,
  input  logic ws,
  input  logic sd,
  output logic bck_rise,
  output logic ws_s,
  output logic sd_s
);
  logic [2:0] stg [STAGES];
  logic       bck_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= {sd, ws, bck};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bck_q <= 1'b0;
    else        bck_q <= stg[STAGES-1][0];
  end

  assign bck_rise = stg[STAGES-1][0] & ~bck_q;
  assign ws_s     = stg[STAGES-1][1];
  assign sd_s     = stg[STAGES-1][2];

  // a bit-clock rise is a single-cycle strobe (R1)
  p_rise_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bck_rise |=> !bck_rise);
endmodule

// File: rtl/i2s_word_rx.sv
module i2s_word_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              ws_bit,
  input  logic              sd_bit,
  output logic              pair_stb,
  output logic [WORD_W-1:0] pair_l,
  output logic [WORD_W-1:0] pair_r
);
  localparam int CW = $clog2(WORD_W + 1);

  logic              ws_last, seen;
  logic [CW-1:0]     n_bits;
  logic [WORD_W-1:0] sh, hold_l;

  wire              chg        = bit_stb && (ws_bit != ws_last);
  wire              room       = n_bits < CW'(WORD_W);
  wire [WORD_W-1:0] word_fin   = room ? {sh[WORD_W-2:0], sd_bit} : sh;
  wire              left_done  = chg && seen && !ws_last;
  wire              pair_fire  = chg && seen && ws_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_last <= 1'b1;
      seen    <= 1'b0;
      n_bits  <= '0;
      sh      <= '0;
      hold_l  <= '0;
    end else if (bit_stb) begin
      ws_last <= ws_bit;
      if (chg) begin
        seen   <= 1'b1;
        n_bits <= '0;
        sh     <= '0;
        if (left_done) hold_l <= word_fin;
      end else if (room) begin
        sh     <= {sh[WORD_W-2:0], sd_bit};
        n_bits <= n_bits + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_stb <= 1'b0;
      pair_l   <= '0;
      pair_r   <= '0;
    end else begin
      pair_stb <= pair_fire;
      if (pair_fire) begin
        pair_l <= hold_l;
        pair_r <= word_fin;
      end
    end
  end

  // one pair hand-off per right-word end, never back to back (R9)
  p_pair_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |=> !pair_stb);
  // a pair only follows a word-select change seen on a bit strobe (R9)
  p_pair_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_stb) |-> $past(bit_stb));
endmodule

// File: rtl/sim_word_tx.sv
module sim_word_tx
  import i2s_simul_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int HALF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_l,
  input  logic [WORD_W-1:0] word_r,
  input  logic              data_inv,
  output logic              clk_raw,
  output logic              dl,
  output logic              dr,
  output logic              le
);
  localparam int PERIOD = 2 * HALF;
  localparam int PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam int BW     = $clog2(WORD_W);

  tx_state_t         state;
  logic [PW-1:0]     ph;
  logic [BW-1:0]     bitn;
  logic [WORD_W-1:0] sh_l, sh_r;

  wire ph_end   = (ph == PW'(PERIOD - 1));
  wire last_bit = (bitn == BW'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      ph    <= '0;
      bitn  <= '0;
      sh_l  <= '0;
      sh_r  <= '0;
    end else begin
      case (state)
        TX_IDLE: if (load) begin
          sh_l  <= word_l ^ {WORD_W{data_inv}};
          sh_r  <= word_r ^ {WORD_W{data_inv}};
          ph    <= '0;
          bitn  <= '0;
          state <= TX_SHIFT;
        end
        TX_SHIFT: begin
          ph <= ph_end ? '0 : ph + 1'b1;
          if (ph_end) begin
            sh_l <= {sh_l[WORD_W-2:0], 1'b0};
            sh_r <= {sh_r[WORD_W-2:0], 1'b0};
            bitn <= bitn + 1'b1;
            if (last_bit) state <= TX_LATCH;
          end
        end
        TX_LATCH: begin
          ph <= ph_end ? '0 : ph + 1'b1;
          if (ph_end) state <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign clk_raw = (state == TX_SHIFT) && (ph >= PW'(HALF));
  assign le      = (state == TX_LATCH);
  assign dl      = sh_l[WORD_W-1];
  assign dr      = sh_r[WORD_W-1];

  // loaded words are the received pair, complemented when asked (R8)
  p_load_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == TX_SHIFT) |->
      (sh_l == ($past(word_l) ^ {WORD_W{$past(data_inv)}})) &&
      (sh_r == ($past(word_r) ^ {WORD_W{$past(data_inv)}})));
  // data holds still across the active mid-bit edge (R3)
  p_mid_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_raw) |-> $stable(sh_l) && $stable(sh_r));
  // latch pulse starts right after the LSB's high phase, all bits gone (R7)
  p_le_after_lsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(le) |-> $past(clk_raw) && (sh_l == '0) && (sh_r == '0));
  // no clock activity during the latch pulse (R5)
  p_le_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> !clk_raw);
endmodule

// File: rtl/i2s_to_simul.sv
module i2s_to_simul
  import i2s_simul_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int HALF   = DEF_HALF,
  parameter int SYNC   = DEF_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i2s_bck,
  input  logic i2s_ws,
  input  logic i2s_sd,
  input  logic cfg_clk_inv,
  input  logic cfg_data_inv,
  output logic dac_clk,
  output logic dac_dl,
  output logic dac_dr,
  output logic dac_le
);
  logic              bck_rise, ws_s, sd_s;
  logic              pair_stb;
  logic [WORD_W-1:0] pair_l, pair_r;
  logic              clk_raw;

  i2s_in_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .bck(i2s_bck), .ws(i2s_ws), .sd(i2s_sd),
    .bck_rise(bck_rise), .ws_s(ws_s), .sd_s(sd_s)
  );

  i2s_word_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .bit_stb(bck_rise), .ws_bit(ws_s), .sd_bit(sd_s),
    .pair_stb(pair_stb), .pair_l(pair_l), .pair_r(pair_r)
  );

  sim_word_tx #(.WORD_W(WORD_W), .HALF(HALF)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(pair_stb), .word_l(pair_l), .word_r(pair_r),
    .data_inv(cfg_data_inv),
    .clk_raw(clk_raw), .dl(dac_dl), .dr(dac_dr), .le(dac_le)
  );

  assign dac_clk = clk_raw ^ cfg_clk_inv;

  // while latching, the output clock rests at its idle level (R6)
  p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dac_le |-> (dac_clk == cfg_clk_inv));
endmodule

// File: tb/tb_i2s_to_simul.sv
module tb_i2s_to_simul;
  logic clk = 1'b0, rst_n = 1'b0;
  logic i2s_bck = 1'b0, i2s_ws = 1'b1, i2s_sd = 1'b0;
  logic cfg_clk_inv = 1'b0, cfg_data_inv = 1'b0;
  logic dac_clk, dac_dl, dac_dr, dac_le;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  i2s_to_simul dut (
    .clk(clk), .rst_n(rst_n), .i2s_bck(i2s_bck), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
    .cfg_clk_inv(cfg_clk_inv), .cfg_data_inv(cfg_data_inv),
    .dac_clk(dac_clk), .dac_dl(dac_dl), .dac_dr(dac_dr), .dac_le(dac_le)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected pairs
  logic [15:0] exp_l [512];
  logic [15:0] exp_r [512];
  int wr_i = 0, rd_i = 0, le_cnt = 0;

  // DAC model monitor
  logic        prev_clk = 1'b0, le_prev = 1'b0, idle_bad = 1'b0;
  logic [15:0] cap_l = '0, cap_r = '0;
  int          nedge = 0, le_len = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_clk = cfg_clk_inv; le_prev = 1'b0; idle_bad = 1'b0;
      nedge = 0; le_len = 0; cap_l = '0; cap_r = '0;
    end else begin
      if (cfg_clk_inv ? (prev_clk && !dac_clk) : (!prev_clk && dac_clk)) begin
        cap_l = {cap_l[14:0], dac_dl};
        cap_r = {cap_r[14:0], dac_dr};
        nedge++;
      end
      if (dac_le) begin
        le_len++;
        if (dac_clk != cfg_clk_inv) idle_bad = 1'b1;
      end
      if (dac_le && !le_prev) begin
        le_cnt++;
        if (rd_i < wr_i) begin
          chk(cap_l == exp_l[rd_i], "R2/R3 left word on dac_dl", {16'h0, cap_l}, {16'h0, exp_l[rd_i]});
          chk(cap_r == exp_r[rd_i], "R2/R3 right word on dac_dr", {16'h0, cap_r}, {16'h0, exp_r[rd_i]});
        end else begin
          chk(1'b0, "R9 unexpected latch pulse", rd_i, wr_i);
        end
        chk(nedge == 16, "R4 active edges per pair", nedge, 16);
        rd_i++;
        nedge = 0;
      end
      if (!dac_le && le_prev) begin
        chk(le_len == 4, "R7 latch pulse length", le_len, 4);
        chk(!idle_bad && nedge == 0, "R5 R6 clock idle during latch", nedge, 0);
        le_len = 0; idle_bad = 1'b0;
      end
      prev_clk = dac_clk;
      le_prev  = dac_le;
    end
  end

  // I2S source: data lags word select by one slot
  logic prev_sd = 1'b0;

  task automatic bit_out(input logic w, input logic d);
    @(negedge clk);
    i2s_bck = 1'b0; i2s_ws = w; i2s_sd = prev_sd; prev_sd = d;
    repeat (4) @(negedge clk);
    i2s_bck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_half(input logic ch, input logic [15:0] word, input int slot);
    for (int j = 0; j < slot; j++)
      bit_out(ch, (j < 16) ? word[15-j] : ~j[0]);
  endtask

  logic [15:0] lf = 16'hACE1;

  task automatic frame(input logic [15:0] l, input logic [15:0] r, input int slot);
    exp_l[wr_i] = cfg_data_inv ? ~l : l;
    exp_r[wr_i] = cfg_data_inv ? ~r : r;
    wr_i++;
    send_half(1'b0, l, slot);
    send_half(1'b1, r, slot);
  endtask

  task automatic run_mode(input logic ci, input logic di, input int slot);
    int sent;
    rst_n = 1'b0; cfg_clk_inv = ci; cfg_data_inv = di;
    i2s_ws = 1'b1; i2s_bck = 1'b0; i2s_sd = 1'b0; prev_sd = 1'b0;
    repeat (5) @(negedge clk);
    // R10 reset state (R6 idle level)
    chk(dac_le == 1'b0 && dac_dl == 1'b0 && dac_dr == 1'b0, "R10 reset outputs", {dac_le, dac_dl, dac_dr}, 0);
    chk(dac_clk == ci, "R6 R10 idle clock level in reset", dac_clk, ci);
    rst_n = 1'b1;
    rd_i = wr_i; le_cnt = 0; sent = 0;
    // partial right word before the stream: must not produce a pair (R9)
    for (int k = 0; k < 5; k++) bit_out(1'b1, k[0]);
    for (int k = 0; k < 16; k++) begin frame(16'h1 << k, ~(16'h1 << k), slot); sent++; end
    frame(16'h8000, 16'h7FFF, slot); frame(16'h0001, 16'hFFFF, slot);
    frame(16'h0000, 16'hFFFF, slot); frame(16'hAAAA, 16'h5555, slot);
    frame(16'hFFFF, 16'h0000, slot); frame(16'h1234, 16'hEDCB, slot);
    sent += 6;
    for (int k = 0; k < 8; k++) begin
      logic [15:0] a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; a = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      frame(a, lf, slot); sent++;
    end
    // flush: close the last right word, then a lone left word (no pair)
    send_half(1'b0, 16'h0F0F, slot);
    bit_out(1'b1, 1'b0);
    repeat (200) @(negedge clk);
    chk(le_cnt == sent, "R9 one latch pulse per frame", le_cnt, sent);
    chk(dac_clk == ci && dac_le == 1'b0, "R5 clock idle after stream", {dac_clk, dac_le}, {ci, 1'b0});
  endtask

  initial begin
    run_mode(1'b0, 1'b0, 16);  // R1 R2 R3 R4
    run_mode(1'b1, 1'b0, 16);  // R6 falling-edge capture
    run_mode(1'b0, 1'b1, 16);  // R8 complement
    run_mode(1'b1, 1'b1, 16);  // R6 R8 together
    run_mode(1'b0, 1'b0, 24);  // R1 extra slot bits ignored
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule